// File: doc/BRIEF.md
# DMA Request Generator

This block is a single-channel engine that turns one software-programmed transfer into a stream of memory request descriptors. Software sets up four 32-bit registers: a 64-bit start address split across two words, a byte count, and a control word. Any write to the control word while the engine is idle starts the transfer. The engine then cuts the transfer into read or write requests. Each request carries an address, a byte length and two header flags: a digest-present flag and a poisoned-data flag.

Every request is limited by three things. The first is a size code in the control word. The second is a configured limit supplied on input pins: the payload limit for writes, the read-request limit for reads. The third is the 4 KB address page, which a request never crosses. For write transfers the engine sends the payload itself, one 32-bit beat at a time after each accepted write request. The payload comes from a selectable built-in pattern.

A busy bit in the control word reads 1 while the transfer runs. The same bit is also driven on a port.

Top module: `dma_req_gen`

## Requirements
- R1: Register word select 0 holds the start address bits 31:0, select 1 holds bits 63:32, and select 2 holds the byte length. Each of these three is written byte by byte under `regByteEn` and reads back as written. In the control word, readback bits other than 31, 22:20, 18:16, 15, 14 and 0 read 0.
- R2: A write to word select 3 with any `regByteEn` bit set, while idle, starts a transfer. The control fields are taken from the full `regWrData` word. From the next cycle on, `busy` is 1 and control readback bit 31 is 1.
- R3: A control write while `busy` is 1 is ignored: the control fields do not change and no second transfer begins. Address and length writes during a transfer update their registers but do not alter the running transfer.
- R4: Control bit 0 selects the direction: 1 gives write requests (`reqWrite`=1) and 0 gives read requests.
- R5: The request size limit is 128 << code. The code is the smaller of control bits 18:16 and the configured code (`cfgMaxPayload` for writes, `cfgMaxReadReq` for reads), and any code above 4 counts as 4 (2048 bytes).
- R6: Start address bits 1:0 are treated as 0. No request crosses a 4096-byte address boundary.
- R7: The length is rounded up to a whole number of DWORDs. Consecutive requests take the largest allowed size, cover contiguous addresses, and their lengths add up to the rounded length.
- R8: Control bit 15 is copied to `reqTd` and control bit 14 to `reqEp` on every request of the transfer.
- R9: Write payload beat k, counted over the whole transfer from 0, depends on the pattern bits: k if bit 22 is set; otherwise bytes {4k+3,4k+2,4k+1,4k} mod 256 (most significant byte first) if bit 21 is set; otherwise 0. Bit 20 alone also gives 0.
- R10: After each accepted write request, exactly length/4 data beats follow before the next request, with `dataLast` high on the final beat only. Read requests have no data beats.
- R11: A zero-length transfer raises `busy` for exactly one cycle and emits no request.
- R12: `reqValid` and the request fields hold steady until `reqReady`. `busy` drops after the last read request is accepted, or after the last write beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWordSel | input | 2 | Word index of the register written |
| regWrData | input | 32 | Register write data |
| regByteEn | input | 4 | Byte enables of the write |
| regRdSel | input | 2 | Word index of the register read |
| regRdData | output | 32 | Read data (combinational) |
| cfgMaxPayload | input | 3 | Configured write payload limit code |
| cfgMaxReadReq | input | 3 | Configured read request limit code |
| reqValid | output | 1 | Request descriptor valid |
| reqReady | input | 1 | Request accepted when high with valid |
| reqWrite | output | 1 | 1 = memory write, 0 = memory read |
| reqAddr | output | 64 | Request start address |
| reqLenBytes | output | 13 | Request length in bytes |
| reqTd | output | 1 | Digest-present flag |
| reqEp | output | 1 | Poisoned-data flag |
| dataValid | output | 1 | Write payload beat valid |
| dataReady | input | 1 | Payload beat accepted |
| dataWord | output | 32 | Payload beat |
| dataLast | output | 1 | Final beat of the current request |
| busy | output | 1 | Transfer in progress |

## Verification
Two functions can fall in one cycle: a software control write, and the final payload beat that completes a transfer. The bench waits until the last beat is on the port with its ready asserted. It then drives a control write with different fields into that same cycle. The write must be dropped, because the engine is still busy on that edge. The bench checks that `busy` then falls, that no further request appears over several cycles, and that the control readback keeps the original fields.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  // strobes sent from the sequencer to the datapath
  typedef struct packed {
    logic load;     // capture programmed registers, begin transfer
    logic advance;  // current request accepted
    logic beat;     // one payload beat accepted
  } dmaStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DATA  = 2'd2
  } dmaState_t;

  typedef struct packed {
    logic [2:0] pattern;   // one-hot payload source, bit 2 wins
    logic [2:0] sizeCode;  // software size limit
    logic       td;
    logic       ep;
    logic       isWrite;
  } dmaCtrl_t;

  localparam int CTL_DIR_BIT  = 0;
  localparam int CTL_EP_BIT   = 14;
  localparam int CTL_TD_BIT   = 15;
  localparam int CTL_SIZE_LO  = 16;
  localparam int CTL_PAT_LO   = 20;
  localparam int CTL_BUSY_BIT = 31;

endpackage

// File: rtl/dma_req_datapath.sv
module dma_req_datapath
  import dma_req_pkg::*;
#(
  parameter int MIN_BYTES_LOG2 = 7,   // size code 0 in bytes, log2
  parameter int MAX_CODE       = 4,   // largest legal size code
  parameter int PAGE_LOG2      = 12   // boundary a request may not cross
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [1:0]           regWordSel,
  input  logic [31:0]          regWrData,
  input  logic [3:0]           regByteEn,
  input  logic [1:0]           regRdSel,
  output logic [31:0]          regRdData,
  input  logic [2:0]           cfgMaxPayload,
  input  logic [2:0]           cfgMaxReadReq,
  input  dmaStrobe_t           strb,
  input  logic                 busy,
  output logic                 ctrlHit,
  output logic                 remZero,
  output logic                 lastBeat,
  output logic                 opWrite,
  output logic [63:0]          reqAddr,
  output logic [PAGE_LOG2:0]   reqLenBytes,
  output logic                 reqTd,
  output logic                 reqEp,
  output logic [31:0]          dataWord
);

  localparam int CHUNK_W = PAGE_LOG2 + 1;
  localparam int REM_W   = 33;
  localparam logic [CHUNK_W-1:0] PAGE_BYTES = CHUNK_W'(2 ** PAGE_LOG2);
  localparam logic [CHUNK_W-1:0] MIN_BYTES  = CHUNK_W'(2 ** MIN_BYTES_LOG2);

  // software-visible registers
  logic [63:0] progAddr;
  logic [31:0] progLen;
  dmaCtrl_t    ctl;

  // working state of the running transfer
  logic [63:0]        curAddr;
  logic [REM_W-1:0]   remBytes;
  logic [CHUNK_W-1:0] beatsLeft;
  logic [31:0]        patIdx;

  assign ctrlHit = regWrEn && (regWordSel == 2'd3) && (|regByteEn);

  // byte-enabled writes to address and length words
  always_ff @(posedge clk) begin
    if (!rstN) begin
      progAddr <= '0;
      progLen  <= '0;
    end else if (regWrEn) begin
      for (int b = 0; b < 4; b++) begin
        if (regByteEn[b]) begin
          case (regWordSel)
            2'd0:    progAddr[8*b +: 8]      <= regWrData[8*b +: 8];
            2'd1:    progAddr[32 + 8*b +: 8] <= regWrData[8*b +: 8];
            2'd2:    progLen[8*b +: 8]       <= regWrData[8*b +: 8];
            default: ;
          endcase
        end
      end
    end
  end

  // control fields only change when a transfer is launched
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctl <= '0;
    end else if (strb.load) begin
      ctl.pattern  <= regWrData[CTL_PAT_LO +: 3];
      ctl.sizeCode <= regWrData[CTL_SIZE_LO +: 3];
      ctl.td       <= regWrData[CTL_TD_BIT];
      ctl.ep       <= regWrData[CTL_EP_BIT];
      ctl.isWrite  <= regWrData[CTL_DIR_BIT];
    end
  end

  // request size: smallest of software code and configured code, clamped
  logic [2:0]         cfgCode;
  logic [2:0]         pickCode;
  logic [2:0]         effCode;
  logic [CHUNK_W-1:0] maxBytes;
  logic [CHUNK_W-1:0] toPage;
  logic [CHUNK_W-1:0] capBytes;
  logic [CHUNK_W-1:0] chunk;

  always_comb begin
    cfgCode  = ctl.isWrite ? cfgMaxPayload : cfgMaxReadReq;
    pickCode = (ctl.sizeCode < cfgCode) ? ctl.sizeCode : cfgCode;
    effCode  = (pickCode > 3'(MAX_CODE)) ? 3'(MAX_CODE) : pickCode;
    maxBytes = MIN_BYTES << effCode;
    toPage   = PAGE_BYTES - {1'b0, curAddr[PAGE_LOG2-1:0]};
    capBytes = (toPage < maxBytes) ? toPage : maxBytes;
    chunk    = (remBytes < REM_W'(capBytes)) ? remBytes[CHUNK_W-1:0] : capBytes;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      remBytes  <= '0;
      beatsLeft <= '0;
      patIdx    <= '0;
    end else if (strb.load) begin
      curAddr   <= {progAddr[63:2], 2'b00};
      remBytes  <= ({1'b0, progLen} + REM_W'(3)) & ~REM_W'(3);
      beatsLeft <= '0;
      patIdx    <= '0;
    end else if (strb.advance) begin
      curAddr   <= curAddr + 64'(chunk);
      remBytes  <= remBytes - REM_W'(chunk);
      beatsLeft <= chunk >> 2;
    end else if (strb.beat) begin
      beatsLeft <= beatsLeft - CHUNK_W'(1);
      patIdx    <= patIdx + 32'd1;
    end
  end

  // payload pattern generator
  logic [7:0]  byteBase;
  logic [31:0] bytePat;

  always_comb begin
    byteBase = {patIdx[5:0], 2'b00};
    bytePat  = {byteBase + 8'd3, byteBase + 8'd2, byteBase + 8'd1, byteBase};
    if (ctl.pattern[2])      dataWord = patIdx;
    else if (ctl.pattern[1]) dataWord = bytePat;
    else                     dataWord = '0;
  end

  // register readback
  logic [31:0] ctlWord;

  always_comb begin
    ctlWord                       = '0;
    ctlWord[CTL_BUSY_BIT]         = busy;
    ctlWord[CTL_PAT_LO +: 3]      = ctl.pattern;
    ctlWord[CTL_SIZE_LO +: 3]     = ctl.sizeCode;
    ctlWord[CTL_TD_BIT]           = ctl.td;
    ctlWord[CTL_EP_BIT]           = ctl.ep;
    ctlWord[CTL_DIR_BIT]          = ctl.isWrite;
    case (regRdSel)
      2'd0:    regRdData = progAddr[31:0];
      2'd1:    regRdData = progAddr[63:32];
      2'd2:    regRdData = progLen;
      default: regRdData = ctlWord;
    endcase
  end

  assign reqAddr     = curAddr;
  assign reqLenBytes = chunk;
  assign reqTd       = ctl.td;
  assign reqEp       = ctl.ep;
  assign opWrite     = ctl.isWrite;
  assign remZero     = (remBytes == '0);
  assign lastBeat    = (beatsLeft == CHUNK_W'(1));

  // after an advance the address is either a page start or still in the same page
  AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> (curAddr[PAGE_LOG2-1:0] == '0) ||
                     (curAddr[63:PAGE_LOG2] == $past(curAddr[63:PAGE_LOG2]))); // R6

  AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ctrlHit) |=> $stable(ctl)); // R3

  AST_REM_DWORD: assert property (@(posedge clk) disable iff (!rstN)
    remBytes[1:0] == 2'b00); // R7

  AST_BEAT_OWED: assert property (@(posedge clk) disable iff (!rstN)
    strb.beat |-> (beatsLeft != '0)); // R10

endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlHit,
  input  logic       remZero,
  input  logic       lastBeat,
  input  logic       opWrite,
  input  logic       reqReady,
  input  logic       dataReady,
  output logic       reqValid,
  output logic       dataValid,
  output logic       busy,
  output dmaStrobe_t strb
);

  dmaState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    case (state)
      ST_IDLE: begin
        if (ctrlHit) begin
          strb.load = 1'b1;
          stateNext = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (remZero) begin
          stateNext = ST_IDLE;
        end else if (reqReady) begin
          strb.advance = 1'b1;
          stateNext    = opWrite ? ST_DATA : ST_ISSUE;
        end
      end
      ST_DATA: begin
        if (dataReady) begin
          strb.beat = 1'b1;
          if (lastBeat) stateNext = ST_ISSUE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqValid  = (state == ST_ISSUE) && !remZero;
  assign dataValid = (state == ST_DATA);
  assign busy      = (state != ST_IDLE);

  AST_ZERO_LEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ISSUE && remZero) |=> !busy); // R11

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> reqValid); // R12

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !dataReady) |=> dataValid); // R10

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && ctrlHit) |=> busy); // R2

endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import dma_req_pkg::*;
#(
  parameter int MIN_BYTES_LOG2 = 7,
  parameter int MAX_CODE       = 4,
  parameter int PAGE_LOG2      = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [1:0]          regWordSel,
  input  logic [31:0]         regWrData,
  input  logic [3:0]          regByteEn,
  input  logic [1:0]          regRdSel,
  output logic [31:0]         regRdData,
  input  logic [2:0]          cfgMaxPayload,
  input  logic [2:0]          cfgMaxReadReq,
  output logic                reqValid,
  input  logic                reqReady,
  output logic                reqWrite,
  output logic [63:0]         reqAddr,
  output logic [PAGE_LOG2:0]  reqLenBytes,
  output logic                reqTd,
  output logic                reqEp,
  output logic                dataValid,
  input  logic                dataReady,
  output logic [31:0]         dataWord,
  output logic                dataLast,
  output logic                busy
);

  dmaStrobe_t strb;
  logic ctrlHit, remZero, lastBeat, opWrite;

  dma_req_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlHit   (ctrlHit),
    .remZero   (remZero),
    .lastBeat  (lastBeat),
    .opWrite   (opWrite),
    .reqReady  (reqReady),
    .dataReady (dataReady),
    .reqValid  (reqValid),
    .dataValid (dataValid),
    .busy      (busy),
    .strb      (strb)
  );

  dma_req_datapath #(
    .MIN_BYTES_LOG2 (MIN_BYTES_LOG2),
    .MAX_CODE       (MAX_CODE),
    .PAGE_LOG2      (PAGE_LOG2)
  ) uPath (
    .clk           (clk),
    .rstN          (rstN),
    .regWrEn       (regWrEn),
    .regWordSel    (regWordSel),
    .regWrData     (regWrData),
    .regByteEn     (regByteEn),
    .regRdSel      (regRdSel),
    .regRdData     (regRdData),
    .cfgMaxPayload (cfgMaxPayload),
    .cfgMaxReadReq (cfgMaxReadReq),
    .strb          (strb),
    .busy          (busy),
    .ctrlHit       (ctrlHit),
    .remZero       (remZero),
    .lastBeat      (lastBeat),
    .opWrite       (opWrite),
    .reqAddr       (reqAddr),
    .reqLenBytes   (reqLenBytes),
    .reqTd         (reqTd),
    .reqEp         (reqEp),
    .dataWord      (dataWord)
  );

  assign reqWrite = opWrite;
  assign dataLast = dataValid && lastBeat;

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> ($stable(reqAddr) && $stable(reqLenBytes))); // R12

  AST_NO_DATA_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> reqWrite); // R10

endmodule

// File: tb/sim_dma_req_gen.sv
module sim_dma_req_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regWordSel = '0;
  logic [31:0] regWrData = '0;
  logic [3:0]  regByteEn = '0;
  logic [1:0]  regRdSel = '0;
  logic [31:0] regRdData;
  logic [2:0]  cfgMaxPayload = 3'd4;
  logic [2:0]  cfgMaxReadReq = 3'd4;
  logic        reqValid, reqWrite, reqTd, reqEp;
  logic        reqReady = 1'b0;
  logic [63:0] reqAddr;
  logic [12:0] reqLenBytes;
  logic        dataValid, dataLast, busy;
  logic        dataReady = 1'b0;
  logic [31:0] dataWord;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_req_gen u0 (.*);

  // ready generation, optionally stalling
  bit        stallOn = 0;
  logic [7:0] cyc = '0;
  always @(posedge clk) begin
    cyc       <= cyc + 8'd1;
    reqReady  <= !stallOn || (cyc[1:0] != 2'b01);
    dataReady <= !stallOn || (cyc[0] ^ cyc[2]);
  end

  // monitor, sampling at the falling edge
  logic [63:0] logAddr [0:255];
  logic [12:0] logLen  [0:255];
  logic        logWr   [0:255];
  logic        logTd   [0:255];
  logic        logEp   [0:255];
  logic [31:0] logData [0:1023];
  int nReq = 0, nBeat = 0, owed = 0, orderErr = 0, lastErr = 0;

  always @(negedge clk) begin
    if (rstN && reqValid && reqReady) begin
      if (nReq < 256) begin
        logAddr[nReq] = reqAddr; logLen[nReq] = reqLenBytes;
        logWr[nReq] = reqWrite; logTd[nReq] = reqTd; logEp[nReq] = reqEp;
      end
      nReq++;
      if (owed != 0) orderErr++;
      owed = reqWrite ? int'(reqLenBytes) / 4 : 0;
    end
    if (rstN && dataValid && dataReady) begin
      if (nBeat < 1024) logData[nBeat] = dataWord;
      nBeat++;
      if (owed == 0) orderErr++;
      else owed--;
      if (dataLast != (owed == 0)) lastErr++;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    regWrEn = 1'b1; regWordSel = sel; regWrData = d; regByteEn = be;
    @(negedge clk);
    regWrEn = 1'b0; regByteEn = '0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [31:0] d);
    regRdSel = sel;
    #1;
    d = regRdData;
  endtask

  task automatic waitIdle(input string rq);
    int n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (busy) chk(0, {rq, " timeout"}, 1, 0);
  endtask

  function automatic logic [31:0] patWord(input int idx, input logic [2:0] p);
    logic [7:0] b;
    b = 8'(idx * 4);
    if (p[2]) return 32'(idx);
    if (p[1]) return {b + 8'd3, b + 8'd2, b + 8'd1, b};
    return 32'h0;
  endfunction

  task automatic launch(input logic [63:0] addr, input logic [31:0] len, input logic [31:0] ctl,
                        input logic [2:0] mp, input logic [2:0] mrr, input bit stall);
    @(negedge clk);
    cfgMaxPayload = mp; cfgMaxReadReq = mrr; stallOn = stall;
    nReq = 0; nBeat = 0; owed = 0; orderErr = 0; lastErr = 0;
    regWrite(2'd0, addr[31:0], 4'hF);
    regWrite(2'd1, addr[63:32], 4'hF);
    regWrite(2'd2, len, 4'hF);
    regWrite(2'd3, ctl, 4'b0100);   // any single byte starts (R2)
  endtask

  // compute the expected requests from the requirements and compare
  task automatic verifyOp(input logic [63:0] addr, input logic [31:0] len, input logic [31:0] ctl,
                          input logic [2:0] mp, input logic [2:0] mrr, input string tag);
    logic [63:0] a;
    logic [32:0] rem;
    int code, cfg, maxb, c, bnd, k, dw, sum;
    bit wr;
    wr   = ctl[0];
    a    = {addr[63:2], 2'b00};                      // R6 low bits ignored
    rem  = ({1'b0, len} + 33'd3) & ~33'd3;           // R7 rounding
    cfg  = wr ? int'(mp) : int'(mrr);
    code = (int'(ctl[18:16]) < cfg) ? int'(ctl[18:16]) : cfg;
    if (code > 4) code = 4;                          // R5 clamp
    maxb = 128 << code;
    k = 0; dw = 0; sum = 0;
    while (rem != 0) begin
      c = maxb;
      bnd = 4096 - int'(a[11:0]);
      if (bnd < c) c = bnd;
      if (rem < 33'(c)) c = int'(rem);
      if (k < nReq && k < 256) begin
        chk(logAddr[k] == a, {tag, " R6 R7 request address"}, logAddr[k], a);
        chk(int'(logLen[k]) == c, {tag, " R5 R6 request length"}, 64'(logLen[k]), 64'(c));
        chk(logWr[k] == wr, {tag, " R4 direction"}, 64'(logWr[k]), 64'(wr));
        chk(logTd[k] == ctl[15] && logEp[k] == ctl[14], {tag, " R8 td/ep"},
            {logTd[k], logEp[k]}, {ctl[15], ctl[14]});
      end
      a = a + 64'(c);
      rem = rem - 33'(c);
      sum = sum + c;
      k++;
    end
    chk(nReq == k, {tag, " R7 request count"}, 64'(nReq), 64'(k));
    dw = wr ? sum / 4 : 0;
    chk(nBeat == dw, {tag, " R10 beat count"}, 64'(nBeat), 64'(dw));
    for (int i = 0; i < dw && i < nBeat && i < 1024; i++)
      chk(logData[i] == patWord(i, ctl[22:20]), {tag, " R9 payload"}, logData[i], patWord(i, ctl[22:20]));
    chk(orderErr == 0, {tag, " R10 beat ordering"}, 64'(orderErr), 0);
    chk(lastErr == 0, {tag, " R10 last flag"}, 64'(lastErr), 0);
  endtask

  task automatic runOp(input logic [63:0] addr, input logic [31:0] len, input logic [31:0] ctl,
                       input logic [2:0] mp, input logic [2:0] mrr, input bit stall, input string tag);
    launch(addr, len, ctl, mp, mrr, stall);
    chk(busy == 1'b1, {tag, " R2 busy after start"}, 64'(busy), 1);
    waitIdle(tag);
    verifyOp(addr, len, ctl, mp, mrr, tag);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    @(negedge clk);
    chk(busy == 0 && reqValid == 0 && dataValid == 0, "R12 idle after reset",
        {busy, reqValid, dataValid}, 0);
    for (int s = 0; s < 4; s++) begin
      regRead(2'(s), d);
      chk(d == 0, "R1 reset readback", d, 0);
    end
  endtask

  task automatic t_regs;
    logic [31:0] d;
    regWrite(2'd0, 32'h11223344, 4'hF);
    regWrite(2'd1, 32'hAABBCCDD, 4'b0101);
    regWrite(2'd2, 32'h00000000, 4'hF);
    regRead(2'd0, d); chk(d == 32'h11223344, "R1 address low", d, 32'h11223344);
    regRead(2'd1, d); chk(d == 32'h00BB00DD, "R1 address high byte enables", d, 32'h00BB00DD);
    // zero-length start with every control bit set
    regWrite(2'd3, 32'hFFFFFFFF, 4'b1000);
    regRead(2'd3, d);
    chk(d[31] == 1'b1, "R2 busy readback", 64'(d[31]), 1);
    chk(busy == 1'b1, "R11 busy first cycle", 64'(busy), 1);
    @(negedge clk);
    chk(busy == 1'b0, "R11 busy cleared after one cycle", 64'(busy), 0);
    chk(nReq == 0, "R11 no request", 64'(nReq), 0);
    regRead(2'd3, d);
    chk(d == 32'h0077C001, "R1 reserved control bits", d, 32'h0077C001);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] d;
    launch(64'h0, 32'd4096, 32'h00008000, 3'd4, 3'd4, 1);
    repeat (5) @(negedge clk);
    regWrite(2'd3, 32'h00470001, 4'hF);
    regWrite(2'd0, 32'h00005000, 4'hF);
    regWrite(2'd2, 32'd8, 4'hF);
    regRead(2'd3, d);
    chk(d == 32'h80008000, "R3 control write ignored while busy", d, 32'h80008000);
    waitIdle("R3");
    verifyOp(64'h0, 32'd4096, 32'h00008000, 3'd4, 3'd4, "R3 running op unchanged");
    regRead(2'd0, d);
    chk(d == 32'h00005000, "R3 address register still writable", d, 32'h00005000);
  endtask

  task automatic t_coincide;
    logic [31:0] d;
    int n = 0;
    launch(64'h100, 32'd8, 32'h00400001, 3'd4, 3'd4, 0);
    while (!(dataValid && dataLast && dataReady) && n < 100) begin
      @(negedge clk);
      n++;
    end
    regWrEn = 1'b1; regWordSel = 2'd3; regWrData = 32'h00000000; regByteEn = 4'h1;
    @(negedge clk);
    regWrEn = 1'b0; regByteEn = '0;
    waitIdle("R3 coincide");
    repeat (6) @(negedge clk);
    chk(nReq == 1 && busy == 0, "R3 control write on last beat dropped", {nReq[31:0], 31'd0, busy}, {32'd1, 32'd0});
    regRead(2'd3, d);
    chk(d == 32'h00400001, "R3 control fields kept", d, 32'h00400001);
    verifyOp(64'h100, 32'd8, 32'h00400001, 3'd4, 3'd4, "R12 coincide op");
  endtask

  initial begin
    #1_500_000ns;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regs();
    // read, TD set, software code 3 vs read limit 1, unaligned start
    runOp(64'h1_0000_0E02, 32'd1001, 32'h00038000, 3'd4, 3'd1, 1, "R4 R5 R8 read");
    // write, dword pattern, EP set, page crossing, payload limit applies
    runOp(64'h2000_0FC0, 32'd600, 32'h00424001, 3'd1, 3'd0, 1, "R9 dword write");
    runOp(64'h40, 32'd130, 32'h00270001, 3'd7, 3'd0, 1, "R9 byte write");
    runOp(64'h80, 32'd64, 32'h00140001, 3'd4, 3'd4, 0, "R9 zero pattern");
    runOp(64'h80, 32'd64, 32'h00040001, 3'd4, 3'd4, 0, "R9 no pattern bits");
    runOp(64'h80, 32'd64, 32'h00640001, 3'd4, 3'd4, 0, "R9 dword priority");
    runOp(64'h0, 32'd5000, 32'h00070000, 3'd0, 3'd6, 0, "R5 clamp read");
    runOp(64'h3000_0000_0000_0F00, 32'd3, 32'h0002C000, 3'd4, 3'd0, 0, "R7 short read");
    t_busy_ignore();
    t_coincide();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule